// File: doc/BRIEF.md
# USB Bulk-Out Frame Encapsulator

This block sits between a transmit frame source and a USB bulk-out endpoint. It takes one Ethernet frame at a time as a byte stream. The byte count of the frame is presented alongside its first byte. Out comes a single byte stream: a four-byte length word, then the frame bytes unchanged, then in some cases a four-byte filler word. The filler word is needed because the receiving side delimits a transfer by a short packet. A transfer whose total size lands exactly on a multiple of one less than the packet size would leave it unable to find the end.

The length word carries the byte count in its lower half and the bitwise inverse of the count in its upper half. It is sent least significant byte first. The filler decision does no division. A residue counter follows every emitted header and body byte modulo (max_pkt − 1). If it wraps to zero on the last body byte, the four filler bytes follow. Both sides use ready/valid handshakes, and body bytes pass straight through without storage.

Top module: `usb_frame_encap`

## Requirements
- R1: The first two output bytes of a transfer are the sampled frame length, bits 7:0 first and then bits 15:8 (zero-extended to 16 bits).
- R2: Output bytes 3 and 4 are the sampled length XOR 0xFFFF, low byte first.
- R3: After the four header bytes, exactly `len` input bytes appear on the output unchanged and in order.
- R4: A filler of bytes 0x00, 0x00, 0xFF, 0xFF follows the last body byte if and only if (len + 4) mod (max_pkt − 1) is zero. This holds for any max_pkt of 8 or more, including 64 and 512.
- R5: out_last is high on exactly one byte per transfer, the final one: the last filler byte if a filler is sent, otherwise the last body byte. It is never high during the header.
- R6: Out of reset and between transfers, out_valid and in_ready are low.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle, provided the source holds its byte during body transfer.
- R8: No input byte is accepted while the header or the filler is being sent. in_ready is high only during the body, and only when out_ready is high.
- R9: in_len is sampled only when a new frame is first offered (in_valid while idle). Later changes to in_len have no effect on the header or the body count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_pkt | input | MPS_W | USB maximum packet size in bytes (8 or more) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_len | input | LEN_W | Frame length in bytes (1 or more), valid with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Encapsulated stream byte |
| out_last | output | 1 | Final byte of the transfer |

## Verification
A wrong length capture shows at the ports on the very first handshaken byte. A broken complement or byte order shows within the first four accepted beats. A residue counter that is off by one shows only at the end of the body: the filler appears or goes missing, and out_last lands on the wrong byte. Frame lengths are therefore chosen on both sides of a wrap for packet sizes 8, 64 and 512. A remaining-count error either cuts the body short or leaves the source stalled, and the per-frame timeout catches the second case. Stall patterns on both handshakes show any loss of state under back-pressure as a missing, repeated or shifted byte.

// File: rtl/usb_frame_encap_pkg.sv
package usb_frame_encap_pkg;

    localparam int HDR_BYTES = 4;
    localparam int PAD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_PAD
    } enc_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } enc_beat_t;

    // Byte of the length word at position idx, transmitted least significant first.
    function automatic logic [7:0] hdr_byte(input logic [15:0] len, input logic [1:0] idx);
        logic [15:0] cpl;
        cpl = len ^ 16'hFFFF;
        case (idx)
            2'd0:    hdr_byte = len[7:0];
            2'd1:    hdr_byte = len[15:8];
            2'd2:    hdr_byte = cpl[7:0];
            default: hdr_byte = cpl[15:8];
        endcase
    endfunction

    // Filler word 0xFFFF0000 in little-endian byte order.
    function automatic logic [7:0] pad_byte(input logic [1:0] idx);
        pad_byte = idx[1] ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/enc_residue.sv
module enc_residue #(
    parameter int MPS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [MPS_W-1:0] max_pkt,
    output logic             at_wrap
);
    logic [MPS_W-1:0] res_q;
    logic [MPS_W-1:0] wrap_val;

    // Residue runs 0 .. max_pkt-2, i.e. modulo (max_pkt - 1).
    assign wrap_val = max_pkt - MPS_W'(2);
    assign at_wrap  = (res_q == wrap_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            res_q <= '0;
        end else if (step) begin
            res_q <= at_wrap ? '0 : res_q + MPS_W'(1);
        end
    end
endmodule

// File: rtl/enc_body_count.sv
module enc_body_count #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic             is_final
);
    logic [LEN_W-1:0] left_q;

    assign is_final = (left_q <= LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= len_in;
        end else if (step && !is_final) begin
            left_q <= left_q - LEN_W'(1);
        end
    end
endmodule

// File: rtl/enc_seq.sv
module enc_seq
    import usb_frame_encap_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [LEN_W-1:0] in_len,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             body_final,
    input  logic             pad_due,
    output logic             len_load,
    output logic             body_step,
    output logic             res_clr,
    output logic             res_step
);
    enc_state_e       st_q;
    logic [1:0]       idx_q;
    logic [LEN_W-1:0] len_q;
    logic [15:0]      len16;
    logic             fire;
    enc_beat_t        beat;

    assign len16 = 16'(len_q);
    assign fire  = out_valid && out_ready;

    always_comb begin
        beat      = '0;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        case (st_q)
            ST_HDR: begin
                out_valid = 1'b1;
                beat.data = hdr_byte(len16, idx_q);
            end
            ST_BODY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                beat.data = in_data;
                beat.last = body_final && !pad_due;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                beat.data = pad_byte(idx_q);
                beat.last = (idx_q == 2'(PAD_BYTES - 1));
            end
            default: ;
        endcase
    end

    assign out_data  = beat.data;
    assign out_last  = beat.last;
    assign len_load  = (st_q == ST_IDLE) && in_valid;
    assign body_step = (st_q == ST_BODY) && fire;
    assign res_clr   = (st_q == ST_IDLE);
    assign res_step  = fire && ((st_q == ST_HDR) || (st_q == ST_BODY));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            len_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        len_q <= in_len;
                        idx_q <= '0;
                        st_q  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == 2'(HDR_BYTES - 1)) st_q <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (fire && body_final) begin
                        idx_q <= '0;
                        st_q  <= pad_due ? ST_PAD : ST_IDLE;
                    end
                end
                default: begin
                    if (fire) begin
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == 2'(PAD_BYTES - 1)) st_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/usb_frame_encap.sv
module usb_frame_encap #(
    parameter int LEN_W = 11,
    parameter int MPS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MPS_W-1:0] max_pkt,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last
);
    logic body_final;
    logic pad_due;
    logic len_load;
    logic body_step;
    logic res_clr;
    logic res_step;

    enc_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_len    (in_len),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .body_final(body_final),
        .pad_due   (pad_due),
        .len_load  (len_load),
        .body_step (body_step),
        .res_clr   (res_clr),
        .res_step  (res_step)
    );

    enc_body_count #(.LEN_W(LEN_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (len_load),
        .len_in  (in_len),
        .step    (body_step),
        .is_final(body_final)
    );

    enc_residue #(.MPS_W(MPS_W)) u_residue (
        .clk    (clk),
        .rst    (rst),
        .clr    (res_clr),
        .step   (res_step),
        .max_pkt(max_pkt),
        .at_wrap(pad_due)
    );
endmodule

// File: rtl/usb_frame_encap_chk.sv
module usb_frame_encap_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);
    logic [2:0] pos_q;
    logic [7:0] b0_q;
    logic [7:0] b1_q;
    logic       fire;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            b0_q  <= '0;
            b1_q  <= '0;
        end else if (fire) begin
            if (pos_q == 3'd0) b0_q <= out_data;
            if (pos_q == 3'd1) b1_q <= out_data;
            if (out_last) pos_q <= '0;
            else if (pos_q < 3'd4) pos_q <= pos_q + 3'd1;
        end
    end

    // R2
    hdr_cpl_lo_chk: assert property (@(posedge clk) disable iff (rst)
        fire && pos_q == 3'd2 |-> out_data == ~b0_q);
    // R2
    hdr_cpl_hi_chk: assert property (@(posedge clk) disable iff (rst)
        fire && pos_q == 3'd3 |-> out_data == ~b1_q);
    // R5
    hdr_not_last_chk: assert property (@(posedge clk) disable iff (rst)
        fire && pos_q < 3'd4 |-> !out_last);
    // R8
    hdr_no_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && pos_q < 3'd4 |-> !in_ready);
    // R3
    body_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> out_valid && out_data == in_data);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

bind usb_frame_encap usb_frame_encap_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
);

// File: tb/usb_frame_encap_bench.sv
module usb_frame_encap_bench;
    localparam int LEN_W = 11;
    localparam int MPS_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [MPS_W-1:0] max_pkt = MPS_W'(64);
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic             out_last;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_b [0:1023];
    logic [7:0] got_b [0:1023];

    always #4 clk = ~clk;

    usb_frame_encap #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_usb_frame_encap (
        .clk      (clk),
        .rst      (rst),
        .max_pkt  (max_pkt),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_len   (in_len),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_last (out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] src_byte(input int i, input int seed);
        return 8'(i * 37 + seed);
    endfunction

    // Compare a region of the transfer; one check per region.
    task automatic cmp_region(input int from, input int upto, input string req);
        int bad_at = -1;
        for (int i = from; i < upto; i++) begin
            if (bad_at < 0 && got_b[i] !== exp_b[i]) bad_at = i;
        end
        if (bad_at < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(got_b[bad_at]), int'(exp_b[bad_at]));
    endtask

    task automatic run_frame(input int len, input int mps, input int mode, input int seed);
        int  nexp;
        int  src    = 0;
        int  ngot   = 0;
        int  lastix = -1;
        int  cyc    = 0;
        int  leaks  = 0;
        bit  done   = 1'b0;
        bit  vld    = 1'b0;
        bit  pad;
        pad = ((len + 4) % (mps - 1)) == 0;
        exp_b[0] = 8'(len);
        exp_b[1] = 8'(len >> 8);
        exp_b[2] = ~8'(len);
        exp_b[3] = ~8'(len >> 8);
        for (int i = 0; i < len; i++) exp_b[4 + i] = src_byte(i, seed);
        nexp = 4 + len;
        if (pad) begin
            exp_b[nexp]     = 8'h00;
            exp_b[nexp + 1] = 8'h00;
            exp_b[nexp + 2] = 8'hFF;
            exp_b[nexp + 3] = 8'hFF;
            nexp += 4;
        end
        max_pkt = MPS_W'(mps);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            if (!vld && src < len) vld = (mode == 0) || (cyc % 4 != 1);
            in_valid  = vld;
            in_data   = src_byte(src, seed);
            // R9: after the first output byte, in_len carries a wrong value
            in_len    = (ngot == 0) ? LEN_W'(len) : LEN_W'(len ^ 'h2A5);
            out_ready = (mode == 0) || (cyc % 3 != 0);
            #1;
            if (in_ready && (ngot < 4 || ngot >= 4 + len)) leaks++;
            if (out_valid && out_ready) begin
                if (ngot < 1024) got_b[ngot] = out_data;
                if (out_last) begin
                    lastix = ngot;
                    done   = 1'b1;
                end
                ngot++;
            end
            if (in_valid && in_ready) begin
                src++;
                vld = 1'b0;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        chk(done, "R5 transfer ended with out_last", int'(done), 1);
        chk(ngot == nexp, "R4 transfer byte count (filler presence)", ngot, nexp);
        chk(lastix == nexp - 1, "R5 out_last position", lastix, nexp - 1);
        chk(leaks == 0, "R8 in_ready outside body", leaks, 0);
        if (ngot == nexp) begin
            cmp_region(0, 2, "R1 length bytes");
            cmp_region(2, 4, "R2 complement bytes");
            cmp_region(4, 4 + len, "R3 body bytes");
            if (pad) cmp_region(4 + len, nexp, "R4 filler bytes");
        end
        chk(!out_valid && !in_ready, "R6 idle after transfer",
            int'({out_valid, in_ready}), 0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !in_ready, "R6 reset state", int'({out_valid, in_ready}), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid && !in_ready, "R6 idle with no input", int'({out_valid, in_ready}), 0);
    endtask

    task automatic test_no_pad_64();  run_frame(60, 64, 0, 3);   endtask  // R4 no filler
    task automatic test_pad_64();     run_frame(59, 64, 0, 11);  endtask  // R4 63 bytes
    task automatic test_pad_64_two(); run_frame(122, 64, 0, 5);  endtask  // R4 126 bytes
    task automatic test_pad_512();    run_frame(507, 512, 0, 9); endtask  // R4 511 bytes
    task automatic test_no_pad_512(); run_frame(508, 512, 0, 1); endtask  // R4 512 bytes
    task automatic test_short();      run_frame(1, 64, 0, 77);   endtask  // R3 single byte
    task automatic test_pad_8();      run_frame(3, 8, 0, 21);    endtask  // R4 small packet
    task automatic test_stall_pad();  run_frame(59, 64, 1, 40);  endtask  // R7 back-pressure
    task automatic test_stall_body(); run_frame(200, 512, 1, 2); endtask  // R7 R9
    task automatic test_back_to_back();
        run_frame(6, 8, 0, 8);    // R4 10 bytes, no filler
        run_frame(10, 8, 1, 13);  // R4 14 bytes, filler
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_no_pad_64();
        test_pad_64();
        test_pad_64_two();
        test_pad_512();
        test_no_pad_512();
        test_short();
        test_pad_8();
        test_stall_pad();
        test_stall_body();
        test_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule